// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous SRAM whose address, control and data are all pipelined. Because write data trails its command by the same two enabled clock edges as read data, the shared data bus can alternate between reads and writes on every cycle without an idle turnaround slot. A host issues one command per enabled clock edge. A command either loads a new address and direction or advances a short burst. Each bus slot belongs to exactly one earlier command.

A small state machine holds the kind of the current burst. Its three states are DESEL (no access), READ and WRITE. There are three transitions. A load with every chip select active goes to READ or WRITE, depending on the write strobe, and captures the byte mask. A load with any select inactive goes to DESEL. An advance stays in the current state, so the burst reuses its first cycle's direction and byte mask. A suspended edge freezes the state and every pipeline stage. A two-bit burst counter steps the low address bits in either linear or interleaved order. A read that follows a write to the same word, one command later, takes the pending bytes straight from the bus.

Top module: `nws_sram`

## Requirements
- R1: Read and write commands may alternate on consecutive enabled edges with no idle cycle, and each returns or stores the correct word.
- R2: A load with `write_n` low and all selects active is a write. Its data is taken from `dq` at the second enabled edge after the command edge.
- R3: During a write, byte b (`dq[9b+8:9b]`) is stored only when `byte_n[b]` was low at the burst's load edge. Other bytes keep their old value.
- R4: Read data is driven on `dq` only in the slot between the first and second enabled edges after the read command edge, not before and not after.
- R5: `dq` is high-impedance in every slot that does not belong to a read, including write-data slots and deselect slots.
- R6: If any bit of `sel_n` is high at a load edge, the cycle is a deselect. Nothing is written and `dq` is not driven in its slot.
- R7: While `suspend` is high, a clock edge changes nothing. Commands are ignored, bus data is not captured, and a driven `dq` keeps its value.
- R8: With `load_n` high, the burst continues with the direction and byte mask of its load cycle. Address bits [1:0] step as base+n (mod 4) when `burst_xor` was 0 at load, or as base XOR n when it was 1. The upper bits stay fixed.
- R9: A read issued on the enabled edge right after a write to the same address returns the new bytes of that write merged with the stored ones.
- R10: After reset, the pipeline is empty and `dq` is not driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset of the control pipeline, active low |
| suspend | input | 1 | High: this edge is ignored and all state holds |
| sel_n | input | 3 | Chip selects, all must be low to access |
| load_n | input | 1 | Low: load new address and direction; high: advance burst |
| write_n | input | 1 | Low at load: write; high at load: read |
| byte_n | input | NB (4) | Per-byte write mask at load, active low |
| addr | input | AW (6) | Word address, taken at load |
| burst_xor | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| dq | inout | NB*BW (36) | Shared data bus |

## Verification
A command is sampled at edge E0. Its bus slot is the whole interval between enabled edges E1 and E2. Read data must be visible there, and write data is captured at E2. Suspended edges do not count toward E1 or E2. The bench drives inputs at the falling edge and samples `dq` just after. The value seen in a tick therefore belongs to the command issued two enabled ticks earlier. Each check is placed at that tick, with suspended ticks left out of the count. The bench also checks the ticks next to a read slot, to confirm the data is neither early nor late.

// File: rtl/nws_pkg.sv
package nws_pkg;
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } slot_e;
endpackage

// File: rtl/nws_burst.sv
module nws_burst #(
    parameter int AW = 6,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic          xor_mode,
    output logic [AW-1:0] nxt_addr
);
    logic [AW-1:0] base;
    logic [CW-1:0] cnt, cnt_n, lo;
    logic          mode_q;

    always_comb begin
        cnt_n = load ? '0 : cnt + CW'(1);
        if (mode_q) lo = base[CW-1:0] ^ cnt_n;
        else        lo = base[CW-1:0] + cnt_n;
        nxt_addr = load ? addr_in : {base[AW-1:CW], lo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base   <= '0;
            cnt    <= '0;
            mode_q <= 1'b0;
        end else if (step) begin
            cnt <= cnt_n;
            if (load) begin
                base   <= addr_in;
                mode_q <= xor_mode;
            end
        end
    end

    AST_BURST_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> $stable(base) && $stable(mode_q)); // R8
endmodule

// File: rtl/nws_ctl.sv
module nws_ctl
    import nws_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          load,
    input  logic          sel_ok,
    input  logic          wr_n,
    input  logic [NB-1:0] be_n,
    input  logic [AW-1:0] nxt_addr,
    output slot_e         s1_op,
    output logic [AW-1:0] s1_addr,
    output slot_e         s2_op,
    output logic [AW-1:0] s2_addr,
    output logic [NB-1:0] s2_be
);
    slot_e         burst_op, nxt_op;
    logic [NB-1:0] burst_be, nxt_be, slot_be, s1_be;

    // next burst state
    always_comb begin
        nxt_op = burst_op;
        nxt_be = burst_be;
        if (load) begin
            if (!sel_ok) begin
                nxt_op = ST_DESEL;
                nxt_be = '0;
            end else if (wr_n) begin
                nxt_op = ST_READ;
                nxt_be = '0;
            end else begin
                nxt_op = ST_WRITE;
                nxt_be = ~be_n;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_op <= ST_DESEL;
            burst_be <= '0;
        end else if (step) begin
            burst_op <= nxt_op;
            burst_be <= nxt_be;
        end
    end

    // slot outputs
    always_comb begin
        unique case (nxt_op)
            ST_DESEL: slot_be = '0;
            ST_READ:  slot_be = '0;
            ST_WRITE: slot_be = nxt_be;
            default:  slot_be = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op   <= ST_DESEL;
            s2_op   <= ST_DESEL;
            s1_addr <= '0;
            s2_addr <= '0;
            s1_be   <= '0;
            s2_be   <= '0;
        end else if (step) begin
            s1_op   <= nxt_op;
            s1_addr <= nxt_addr;
            s1_be   <= slot_be;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(s1_op) && $stable(s2_op) && $stable(s1_addr) && $stable(s2_addr)); // R7
    AST_BURST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> $stable(burst_op) && $stable(burst_be)); // R8
    AST_DESEL_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && load && !sel_ok) |=> s1_op == ST_DESEL); // R6
    AST_PIPE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> s2_op == $past(s1_op)); // R4
endmodule

// File: rtl/nws_core.sv
module nws_core #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             rd_go,
    input  logic [AW-1:0]    rd_addr,
    input  logic             wr_go,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NB-1:0]    wr_be,
    input  logic [NB*BW-1:0] bus_in,
    output logic [NB*BW-1:0] rd_data,
    output logic             rd_oe
);
    localparam int DW    = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] word;

    // array word with the write committing on this edge merged in
    always_comb begin
        word = mem[rd_addr];
        for (int b = 0; b < NB; b++) begin
            if (wr_go && wr_be[b] && (wr_addr == rd_addr))
                word[b*BW +: BW] = bus_in[b*BW +: BW];
        end
    end

    always_ff @(posedge clk) begin
        if (step && wr_go) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_be[b]) mem[wr_addr][b*BW +: BW] <= bus_in[b*BW +: BW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_oe   <= 1'b0;
            rd_data <= '0;
        end else if (step) begin
            rd_oe <= rd_go;
            if (rd_go) rd_data <= word;
        end
    end

    AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> !rd_oe); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(rd_oe) && $stable(rd_data)); // R7
endmodule

// File: rtl/nws_sram.sv
module nws_sram
    import nws_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             suspend,
    input  logic [2:0]       sel_n,
    input  logic             load_n,
    input  logic             write_n,
    input  logic [NB-1:0]    byte_n,
    input  logic [AW-1:0]    addr,
    input  logic             burst_xor,
    inout  wire  [NB*BW-1:0] dq
);
    localparam int DW = NB * BW;

    logic          step, load, sel_ok, oe;
    logic [AW-1:0] nxt_addr, s1_addr, s2_addr;
    logic [NB-1:0] s2_be;
    logic [DW-1:0] rd_data;
    slot_e         s1_op, s2_op;

    assign step   = !suspend;
    assign load   = !load_n;
    assign sel_ok = ~|sel_n;

    nws_burst #(.AW(AW), .CW(2)) u_burst (
        .clk(clk), .rst_n(rst_n), .step(step), .load(load),
        .addr_in(addr), .xor_mode(burst_xor), .nxt_addr(nxt_addr)
    );

    nws_ctl #(.AW(AW), .NB(NB)) u_ctl (
        .clk(clk), .rst_n(rst_n), .step(step), .load(load), .sel_ok(sel_ok),
        .wr_n(write_n), .be_n(byte_n), .nxt_addr(nxt_addr),
        .s1_op(s1_op), .s1_addr(s1_addr), .s2_op(s2_op), .s2_addr(s2_addr),
        .s2_be(s2_be)
    );

    nws_core #(.AW(AW), .NB(NB), .BW(BW)) u_core (
        .clk(clk), .rst_n(rst_n), .step(step),
        .rd_go(s1_op == ST_READ), .rd_addr(s1_addr),
        .wr_go(s2_op == ST_WRITE), .wr_addr(s2_addr), .wr_be(s2_be),
        .bus_in(dq), .rd_data(rd_data), .rd_oe(oe)
    );

    assign dq = oe ? rd_data : {DW{1'bz}};
endmodule

// File: tb/nws_sram_test.sv
module nws_sram_test;
    localparam int CLK_T = 10;
    localparam logic [35:0] HIZ = {36{1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        suspend = 1'b0;
    logic [2:0]  sel_n = 3'b111;
    logic        load_n = 1'b0;
    logic        write_n = 1'b1;
    logic [3:0]  byte_n = 4'hF;
    logic [5:0]  addr = '0;
    logic        burst_xor = 1'b0;
    logic        drv_en = 1'b0;
    logic [35:0] drv_val = '0;
    wire  [35:0] dq;
    int total = 0;
    int bad = 0;
    logic finished = 1'b0;

    assign dq = drv_en ? drv_val : {36{1'bz}};
    for (genvar i = 0; i < 36; i++) begin : g_pu
        pullup (dq[i]);
    end

    always #(CLK_T/2) clk = ~clk;

    nws_sram uut (
        .clk(clk), .rst_n(rst_n), .suspend(suspend), .sel_n(sel_n),
        .load_n(load_n), .write_n(write_n), .byte_n(byte_n), .addr(addr),
        .burst_xor(burst_xor), .dq(dq)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw, input logic [3:0] bn);
        logic [35:0] r = old;
        for (int b = 0; b < 4; b++) if (!bn[b]) r[b*9 +: 9] = nw[b*9 +: 9];
        return r;
    endfunction

    // one tick: drive inputs for the next edge and the bus for this slot, then sample
    task automatic tick(input logic ld_n_i, input logic wn_i, input logic [2:0] sn_i,
                        input logic [3:0] bn_i, input logic [5:0] a_i, input logic sus_i,
                        input logic de_i, input logic [35:0] dv_i, output logic [35:0] s);
        @(negedge clk);
        load_n = ld_n_i; write_n = wn_i; sel_n = sn_i; byte_n = bn_i;
        addr = a_i; suspend = sus_i; drv_en = de_i; drv_val = dv_i;
        #1;
        s = dq;
    endtask

    task automatic nop(input logic de, input logic [35:0] dv, output logic [35:0] s);
        tick(1'b0, 1'b1, 3'b111, 4'hF, 6'd0, 1'b0, de, dv, s);
    endtask
    task automatic rd(input logic [5:0] a, input logic de, input logic [35:0] dv, output logic [35:0] s);
        tick(1'b0, 1'b1, 3'b000, 4'hF, a, 1'b0, de, dv, s);
    endtask
    task automatic wr(input logic [5:0] a, input logic [3:0] bn, input logic de, input logic [35:0] dv, output logic [35:0] s);
        tick(1'b0, 1'b0, 3'b000, bn, a, 1'b0, de, dv, s);
    endtask
    task automatic adv(input logic de, input logic [35:0] dv, output logic [35:0] s);
        tick(1'b1, 1'b0, 3'b000, 4'h0, 6'd0, 1'b0, de, dv, s);
    endtask

    task automatic t_reset();
        logic [35:0] s;
        nop(0, 0, s); chk("R10 idle bus after reset", s, HIZ);
        nop(0, 0, s); chk("R5 deselect slot", s, HIZ);
    endtask

    task automatic t_back_to_back();
        logic [35:0] s;
        logic [35:0] d1 = 36'h123456789, d2 = 36'h0ABCDEF01, d3 = 36'h55AA33CC7;
        wr(6'd1, 4'h0, 0, 0, s);
        wr(6'd2, 4'h0, 0, 0, s);
        rd(6'd1, 1, d1, s);
        rd(6'd2, 1, d2, s);
        wr(6'd3, 4'h0, 0, 0, s); chk("R1 read after writes", s, d1);
        rd(6'd3, 0, 0, s);       chk("R2 second word", s, d2);
        nop(1, d3, s);
        nop(0, 0, s);            chk("R9 forwarded full word", s, d3);
        nop(0, 0, s);            chk("R5 deselect after read", s, HIZ);
        rd(6'd1, 0, 0, s);
        nop(0, 0, s);            chk("R4 not early", s, HIZ);
        nop(0, 0, s);            chk("R4 read slot", s, d1);
        nop(0, 0, s);            chk("R4 not late", s, HIZ);
    endtask

    task automatic t_bytes();
        logic [35:0] s;
        logic [35:0] a = 36'h13579BDF1, b = 36'h2468ACE02;
        wr(6'd8, 4'h0, 0, 0, s); nop(0, 0, s); nop(1, a, s);
        wr(6'd8, 4'b1010, 0, 0, s); nop(0, 0, s); nop(1, b, s);
        rd(6'd8, 0, 0, s); nop(0, 0, s);
        nop(0, 0, s); chk("R3 byte mask 1010", s, merge(a, b, 4'b1010));
    endtask

    task automatic t_forward();
        logic [35:0] s;
        logic [35:0] a = 36'h0F1E2D3C4, b = 36'h1A2B3C4D5;
        wr(6'd9, 4'h0, 0, 0, s); nop(0, 0, s); nop(1, a, s);
        wr(6'd9, 4'b0110, 0, 0, s);
        rd(6'd9, 0, 0, s);
        nop(1, b, s);
        nop(0, 0, s); chk("R9 forwarded partial", s, merge(a, b, 4'b0110));
    endtask

    task automatic t_desel();
        logic [35:0] s;
        for (int i = 0; i < 3; i++) begin
            logic [35:0] a = 36'h011111111 * (i + 1);
            logic [5:0]  ad = 6'd20 + 6'(i);
            logic [2:0]  sn = 3'(1 << i);
            wr(ad, 4'h0, 0, 0, s); nop(0, 0, s); nop(1, a, s);
            tick(1'b0, 1'b0, sn, 4'h0, ad, 1'b0, 0, 0, s);
            tick(1'b0, 1'b1, sn, 4'hF, ad, 1'b0, 0, 0, s);
            nop(1, 36'h0CAFEF00D, s);
            rd(ad, 0, 0, s); chk("R6 no drive when deselected", s, HIZ);
            nop(0, 0, s);
            nop(0, 0, s); chk("R6 no write when deselected", s, a);
        end
    endtask

    task automatic t_suspend();
        logic [35:0] s;
        logic [35:0] d = 36'h3C3C3C3C3, e = 36'h0A5A5A5A5;
        wr(6'd31, 4'h0, 0, 0, s); nop(0, 0, s); nop(1, e, s);
        wr(6'd30, 4'h0, 0, 0, s); nop(0, 0, s);
        tick(1'b0, 1'b0, 3'b000, 4'h0, 6'd31, 1'b1, 1, 36'h0DEADBEEF, s);
        nop(1, d, s);
        rd(6'd30, 0, 0, s); nop(0, 0, s);
        nop(0, 0, s); chk("R7 data not taken while suspended", s, d);
        rd(6'd31, 0, 0, s); nop(0, 0, s);
        nop(0, 0, s); chk("R7 command ignored while suspended", s, e);
        rd(6'd30, 0, 0, s); nop(0, 0, s);
        tick(1'b0, 1'b1, 3'b111, 4'hF, 6'd0, 1'b1, 0, 0, s); chk("R7 read slot", s, d);
        tick(1'b0, 1'b1, 3'b111, 4'hF, 6'd0, 1'b1, 0, 0, s); chk("R7 output held", s, d);
        nop(0, 0, s); chk("R7 output held at resume", s, d);
        nop(0, 0, s); chk("R7 next slot idle", s, HIZ);
    endtask

    task automatic t_burst();
        logic [35:0] s;
        logic [35:0] v [4];
        logic [35:0] n [4];
        for (int k = 0; k < 4; k++) begin
            v[k] = 36'h100000000 + 36'h010203045 * (k + 1);
            n[k] = 36'h0000000A0 + 36'(k);
        end
        wr(6'd12, 4'h0, 0, 0, s); wr(6'd13, 4'h0, 0, 0, s);
        wr(6'd14, 4'h0, 1, v[0], s); wr(6'd15, 4'h0, 1, v[1], s);
        nop(1, v[2], s); nop(1, v[3], s);
        // linear from 13: 13,14,15,12
        burst_xor = 1'b0;
        rd(6'd13, 0, 0, s); adv(0, 0, s);
        adv(0, 0, s); chk("R8 linear beat0", s, v[1]);
        adv(0, 0, s); chk("R8 linear beat1", s, v[2]);
        nop(0, 0, s); chk("R8 linear beat2", s, v[3]);
        nop(0, 0, s); chk("R8 linear wrap", s, v[0]);
        nop(0, 0, s); chk("R8 burst end idle", s, HIZ);
        // interleaved from 13: 13,12,15,14
        burst_xor = 1'b1;
        rd(6'd13, 0, 0, s); adv(0, 0, s);
        adv(0, 0, s); chk("R8 xor beat0", s, v[1]);
        adv(0, 0, s); chk("R8 xor beat1", s, v[0]);
        nop(0, 0, s); chk("R8 xor beat2", s, v[3]);
        nop(0, 0, s); chk("R8 xor beat3", s, v[2]);
        // write burst, byte 0 only; advances carry write_n=0 and byte_n=0 which must be ignored
        burst_xor = 1'b0;
        wr(6'd12, 4'b1110, 0, 0, s); adv(0, 0, s);
        adv(1, n[0], s); adv(1, n[1], s);
        nop(1, n[2], s); nop(1, n[3], s);
        rd(6'd12, 0, 0, s); tick(1'b1, 1'b0, 3'b000, 4'h0, 6'd0, 1'b0, 0, 0, s);
        tick(1'b1, 1'b1, 3'b000, 4'h0, 6'd0, 1'b0, 0, 0, s);
        chk("R8 write burst keeps mask w12", s, merge(v[0], n[0], 4'b1110));
        adv(0, 0, s); chk("R8 write burst w13", s, merge(v[1], n[1], 4'b1110));
        nop(0, 0, s); chk("R8 read burst keeps direction w14", s, merge(v[2], n[2], 4'b1110));
        nop(0, 0, s); chk("R8 write burst w15", s, merge(v[3], n[3], 4'b1110));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_back_to_back();
        t_bytes();
        t_forward();
        t_desel();
        t_suspend();
        t_burst();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule